// File: doc/BRIEF.md
# Indexed Permission Decoder

This block holds a 64-bit table of sixteen 4-bit permission codes that software loads through a plain write port. On each translation lookup a 4-bit index selects one code. The block decodes that code into separate read, write and execute grants, plus shadow-stack read and shadow-stack write grants. Alongside the grants it reports whether a later overlay stage should be applied to the result, and whether the write-xor-execute policy covers the selected code. A policy control input removes execute from a code that the write-xor-execute policy covers.

A global enable switches indirection on and off. While it is low, the table has no influence on the outputs: the read, write and execute grants follow a pass-through permission input, and every flag and shadow-stack grant is low. The path from the index and the stored table to the outputs is purely combinational. Writes are registered and apply to lookups from the cycle after the write edge.

Top module: `pind_lookup`

## Requirements
- R1: After reset every table entry holds code 0000. With indirection enabled, every index then yields no read, write, execute or shadow-stack grant, overlay flag high and write-xor-execute flag low.
- R2: A write with `cfg_we` high loads `cfg_wdata` into the table at the rising clock edge, and lookups use the new value only after that edge. Entry m occupies bits [4m+3:4m] of the table, for m from 0 to 15.
- R3: With indirection enabled, the selected code decodes to these grants: 0001 and 1000 read; 0010 execute; 0011 and 1010 read and execute; 0101 and 1100 read and write; 0110, 0111 and 1110 read, write and execute; 0000 nothing.
- R4: Codes 0100, 1011, 1101 and 1111 are reserved and grant nothing (no read, write, execute or shadow-stack grant).
- R5: With indirection enabled, the overlay flag is high exactly when bit 3 of the selected code is 0, reserved codes included.
- R6: Code 1001 grants read, shadow-stack read and shadow-stack write, and no write or execute. No other code grants either shadow-stack permission.
- R7: The write-xor-execute flag is high only when indirection is enabled and the selected code is 0110.
- R8: When the write-xor-execute flag is high and `wx_force` is high, the execute grant is low. `wx_force` has no effect on any other code.
- R9: With `ind_en` low, `perm_r`, `perm_w` and `perm_x` equal bits 0, 1 and 2 of `byp_perm`. Overlay flag, write-xor-execute flag and both shadow-stack grants are low, whatever the table holds.
- R10: A change of `idx`, `ind_en`, `wx_force` or `byp_perm` reaches the outputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write enable |
| cfg_wdata | input | 64 | Table write data |
| ind_en | input | 1 | Indirection enable |
| wx_force | input | 1 | Write-xor-execute policy control |
| idx | input | 4 | Entry index for the lookup |
| byp_perm | input | 3 | Pass-through grants {execute, write, read} |
| perm_r | output | 1 | Read grant |
| perm_w | output | 1 | Write grant |
| perm_x | output | 1 | Execute grant |
| ss_rd | output | 1 | Shadow-stack read grant |
| ss_wr | output | 1 | Shadow-stack write grant |
| overlay_on | output | 1 | Overlay applies to this lookup |
| wx_applies | output | 1 | Write-xor-execute policy covers this code |

## Verification
Lookup results are due in the same cycle as the index or control change, so the bench drives inputs on the falling edge and samples one nanosecond later, before any rising edge can intervene. A table write is due one rising edge after `cfg_we` is raised; the bench samples once just before that edge, to see the old decode still in place, and once just after it, to see the new one. Reset state is sampled after release with no write in between.

// File: rtl/pind_pkg.sv
package pind_pkg;

   typedef struct packed {
      logic rd;
      logic wr;
      logic ex;
      logic ss_rd;
      logic ss_wr;
      logic ovl;
      logic wxa;
   } pind_grant_t;

   // Fixed 4-bit code to grant mapping; bit 3 low means overlay applies.
   function automatic pind_grant_t pind_decode_code(input logic [3:0] code);
      pind_grant_t g;
      g       = '0;
      g.ovl   = ~code[3];
      unique case (code)
         4'b0001, 4'b1000: g.rd = 1'b1;
         4'b0010:          g.ex = 1'b1;
         4'b0011, 4'b1010: begin g.rd = 1'b1; g.ex = 1'b1; end
         4'b0101, 4'b1100: begin g.rd = 1'b1; g.wr = 1'b1; end
         4'b0110:          begin g.rd = 1'b1; g.wr = 1'b1; g.ex = 1'b1; g.wxa = 1'b1; end
         4'b0111, 4'b1110: begin g.rd = 1'b1; g.wr = 1'b1; g.ex = 1'b1; end
         4'b1001:          begin g.rd = 1'b1; g.ss_rd = 1'b1; g.ss_wr = 1'b1; end
         default:          ; // 0000 and reserved codes: nothing granted
      endcase
      return g;
   endfunction

endpackage

// File: rtl/pind_store.sv
module pind_store #(
   parameter int TBL_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [TBL_W-1:0] wdata,
   output logic [TBL_W-1:0] tbl_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tbl_q <= '0;
      else if (we) tbl_q <= wdata;
   end
endmodule

// File: rtl/pind_select.sv
module pind_select #(
   parameter int N_ENT   = 16,
   parameter int ENT_W   = 4,
   localparam int IDX_W  = $clog2(N_ENT),
   localparam int TBL_W  = N_ENT * ENT_W
) (
   input  logic [TBL_W-1:0] tbl,
   input  logic [IDX_W-1:0] idx,
   output logic [ENT_W-1:0] code
);
   logic [ENT_W-1:0] ent [N_ENT];

   for (genvar m = 0; m < N_ENT; m++) begin : g_ent
      assign ent[m] = tbl[m*ENT_W +: ENT_W];
   end

   assign code = ent[idx];
endmodule

// File: rtl/pind_decode.sv
module pind_decode
   import pind_pkg::*;
#(
   parameter bit SS_EN = 1'b1
) (
   input  logic [3:0]  code,
   input  logic        wx_force,
   output pind_grant_t grant
);
   pind_grant_t raw;

   always_comb raw = pind_decode_code(code);

   if (SS_EN) begin : g_ss
      always_comb begin
         grant    = raw;
         grant.ex = raw.ex & ~(raw.wxa & wx_force);
      end
   end else begin : g_no_ss
      always_comb begin
         grant       = raw;
         grant.ex    = raw.ex & ~(raw.wxa & wx_force);
         grant.ss_rd = 1'b0;
         grant.ss_wr = 1'b0;
      end
   end
endmodule

// File: rtl/pind_lookup.sv
module pind_lookup
   import pind_pkg::*;
#(
   parameter int N_ENT  = 16,
   parameter int ENT_W  = 4,
   parameter bit SS_EN  = 1'b1,
   localparam int IDX_W = $clog2(N_ENT),
   localparam int TBL_W = N_ENT * ENT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [TBL_W-1:0] cfg_wdata,
   input  logic             ind_en,
   input  logic             wx_force,
   input  logic [IDX_W-1:0] idx,
   input  logic [2:0]       byp_perm,
   output logic             perm_r,
   output logic             perm_w,
   output logic             perm_x,
   output logic             ss_rd,
   output logic             ss_wr,
   output logic             overlay_on,
   output logic             wx_applies
);
   if (ENT_W != 4) begin : g_bad_w
      $fatal(1, "pind_lookup: entry width must be 4");
   end
   if (N_ENT != (1 << IDX_W)) begin : g_bad_n
      $fatal(1, "pind_lookup: entry count must be a power of two");
   end

   logic [TBL_W-1:0] tbl_q;
   logic [ENT_W-1:0] sel_code;
   pind_grant_t      grant;

   pind_store #(.TBL_W(TBL_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .tbl_q(tbl_q)
   );

   pind_select #(.N_ENT(N_ENT), .ENT_W(ENT_W)) u_sel (
      .tbl(tbl_q), .idx(idx), .code(sel_code)
   );

   pind_decode #(.SS_EN(SS_EN)) u_dec (
      .code(sel_code), .wx_force(wx_force), .grant(grant)
   );

   always_comb begin
      if (ind_en) begin
         perm_r     = grant.rd;
         perm_w     = grant.wr;
         perm_x     = grant.ex;
         ss_rd      = grant.ss_rd;
         ss_wr      = grant.ss_wr;
         overlay_on = grant.ovl;
         wx_applies = grant.wxa;
      end else begin
         perm_r     = byp_perm[0];
         perm_w     = byp_perm[1];
         perm_x     = byp_perm[2];
         ss_rd      = 1'b0;
         ss_wr      = 1'b0;
         overlay_on = 1'b0;
         wx_applies = 1'b0;
      end
   end
endmodule

// File: rtl/pind_lookup_chk.sv
module pind_lookup_chk #(
   parameter int TBL_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [TBL_W-1:0] cfg_wdata,
   input logic             ind_en,
   input logic             wx_force,
   input logic [2:0]       byp_perm,
   input logic [TBL_W-1:0] tbl_q,
   input logic [3:0]       sel_code,
   input logic             perm_r,
   input logic             perm_w,
   input logic             perm_x,
   input logic             ss_rd,
   input logic             ss_wr,
   input logic             overlay_on,
   input logic             wx_applies
);
   logic rsv;
   assign rsv = (sel_code == 4'b0100) || (sel_code == 4'b1011) ||
                (sel_code == 4'b1101) || (sel_code == 4'b1111);

   AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> tbl_q == $past(cfg_wdata)); // R2
   AST_RSV_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_en && rsv) |-> !(perm_r || perm_w || perm_x || ss_rd || ss_wr)); // R4
   AST_OVL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      ind_en |-> overlay_on == !sel_code[3]); // R5
   AST_SS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_rd || ss_wr) |-> (ind_en && sel_code == 4'b1001 && perm_r && !perm_w)); // R6
   AST_WX_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      wx_applies |-> (ind_en && sel_code == 4'b0110)); // R7
   AST_WX_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      (wx_applies && wx_force) |-> !perm_x); // R8
   AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      !ind_en |-> ({perm_x, perm_w, perm_r} == byp_perm &&
                   !overlay_on && !wx_applies && !ss_rd && !ss_wr)); // R9
endmodule

bind pind_lookup pind_lookup_chk #(.TBL_W(TBL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
   .ind_en(ind_en), .wx_force(wx_force), .byp_perm(byp_perm),
   .tbl_q(tbl_q), .sel_code(sel_code),
   .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
   .ss_rd(ss_rd), .ss_wr(ss_wr), .overlay_on(overlay_on), .wx_applies(wx_applies)
);

// File: tb/pind_lookup_test.sv
module pind_lookup_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [63:0] cfg_wdata = '0;
   logic        ind_en = 1'b0;
   logic        wx_force = 1'b0;
   logic [3:0]  idx = '0;
   logic [2:0]  byp_perm = '0;
   logic perm_r, perm_w, perm_x, ss_rd, ss_wr, overlay_on, wx_applies;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pind_lookup uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .ind_en(ind_en), .wx_force(wx_force), .idx(idx), .byp_perm(byp_perm),
      .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
      .ss_rd(ss_rd), .ss_wr(ss_wr), .overlay_on(overlay_on), .wx_applies(wx_applies)
   );

   // Expected {r,w,x,ss_rd,ss_wr,overlay,wx} per code, from R3..R7
   localparam logic [6:0] EXP [16] = '{
      7'b0000010, 7'b1000010, 7'b0010010, 7'b1010010,
      7'b0000010, 7'b1100010, 7'b1110011, 7'b1110010,
      7'b1000000, 7'b1001100, 7'b1010000, 7'b0000000,
      7'b1100000, 7'b0000000, 7'b1110000, 7'b0000000
   };

   function automatic logic [6:0] outs();
      return {perm_r, perm_w, perm_x, ss_rd, ss_wr, overlay_on, wx_applies};
   endfunction

   task automatic check(input string req, input logic [6:0] exp);
      n_run++;
      if (outs() !== exp) begin
         n_fail++;
         $display("FAIL %s idx=%0d act=%b exp=%b", req, idx, outs(), exp);
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      ind_en = 1'b1;
      // R1: reset state, every entry code 0000
      for (int i = 0; i < 16; i++) begin
         @(negedge clk) idx = 4'(i); #1;
         check("R1", EXP[0]);
      end
      // R2: write entry m = code m; old decode held until the edge
      @(negedge clk) cfg_we = 1'b1; cfg_wdata = 64'hFEDC_BA98_7654_3210; idx = 4'd1;
      #1 check("R2", EXP[0]);
      @(posedge clk); #1 cfg_we = 1'b0;
      check("R2", EXP[1]);
      // Vector table walk: R3 R4 R5 R6 R7
      for (int i = 0; i < 16; i++) begin
         @(negedge clk) idx = 4'(i); #1;
         check("R3/R4/R5/R6/R7", EXP[i]);
      end
      // R8: policy control set; only code 0110 loses execute
      wx_force = 1'b1;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk) idx = 4'(i); #1;
         check("R8", (i == 6) ? 7'b1100011 : EXP[i]);
      end
      // R10: wx_force drop reflects with no clock edge
      @(negedge clk) idx = 4'd6; #1 wx_force = 1'b0; #1;
      check("R10", EXP[6]);
      // R2: reversed table; entry 0 now holds code 1111 at bits [3:0]
      @(negedge clk) cfg_we = 1'b1; cfg_wdata = 64'h0123_4567_89AB_CDEF;
      @(posedge clk); #1 cfg_we = 1'b0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk) idx = 4'(i); #1;
         check("R2", EXP[15-i]);
      end
      // R9: disabled, outputs mirror bypass, table ignored
      for (int b = 0; b < 8; b++) begin
         @(negedge clk) ind_en = 1'b0; byp_perm = 3'(b); idx = 4'd6; wx_force = 1'b1; #1;
         check("R9", {byp_perm[0], byp_perm[1], byp_perm[2], 4'b0000});
         idx = 4'd9; #1;
         check("R9", {byp_perm[0], byp_perm[1], byp_perm[2], 4'b0000});
      end
      // R10: enable toggled mid-cycle, decode of code 1001 at index 6
      wx_force = 1'b0; idx = 4'd6; #1 ind_en = 1'b1; #1;
      check("R10", EXP[9]);
      // R4 + R2: all entries reserved 1011, then 0100
      @(negedge clk) cfg_we = 1'b1; cfg_wdata = {16{4'b1011}};
      @(posedge clk); #1 cfg_we = 1'b0;
      @(negedge clk) idx = 4'd15; #1 check("R4", EXP[11]);
      @(negedge clk) cfg_we = 1'b1; cfg_wdata = {16{4'b0100}};
      @(posedge clk); #1 cfg_we = 1'b0;
      @(negedge clk) idx = 4'd7; #1 check("R4", EXP[4]);
      // R1: reset clears the table again
      @(negedge clk) rst_n = 1'b0; #1 rst_n = 1'b1; #1;
      check("R1", EXP[0]);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule